// File: doc/BRIEF.md
# Raster line interrupt generator

This block asks the processor for an interrupt when the display beam reaches a programmed scan line. It also merges in the legacy once-per-frame interrupt. Software programs a 9-bit target line through two 8-bit registers. The control register holds the enables and the top bit of the target. The value register holds the low eight bits of the target.

The video timing generator supplies two inputs: the horizontal pixel position, and a vertical line count that starts at 0 on the first line of visible pixels. The line request is raised early, while the beam is still on the line before the target. It is raised only in the horizontal stretch that follows the pixel area of that line, so a handler can start before the target line is drawn. The interrupt output is a level. It is registered, so it follows its inputs by one clock. Bit 7 of the control register mirrors this level.

Top module: `raster_line_irq`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the value register (address 1) reads 0x00 and `intOut` is 0. The legacy frame interrupt is therefore enabled and the line interrupt disabled.
- R2: A write to address 0 stores bits 2:0: bit 2 masks the frame interrupt, bit 1 enables the line interrupt, and bit 0 is target bit 8. Written bits 7:3 are ignored, and bits 6:3 always read 0. A write to address 1 stores target bits 7:0, and that register reads back unchanged.
- R3: With the line interrupt enabled, `intOut` is 1 in the clock after a cycle in which `vLine` equals target minus 1 and `hPos` lies in 256..319 inclusive.
- R4: The line source never raises `intOut` for `hPos` below 256 or above 319, nor on any line other than the one before the target.
- R5: The compare wraps modulo `LINE_COUNT`. Target 0 fires on line `LINE_COUNT`-1, and a target with bit 8 set is matched on the full 9-bit value.
- R6: A target of `LINE_COUNT` or above never raises `intOut` from the line source.
- R7: With control bit 1 at 0, the line source never raises `intOut`.
- R8: With control bit 2 at 0, a cycle with `frameIrq` high gives `intOut` 1 in the next clock. With control bit 2 at 1, `frameIrq` has no effect on `intOut`.
- R9: Bit 7 of the control register reads the current `intOut` level, whether or not the processor is taking interrupts.
- R10: When a line match and an unmasked frame pulse fall in the same cycle, `intOut` is 1 in the next clock. Masking the frame pulse does not suppress a line match in the same cycle.
- R11: A register write takes effect on the compare in the clock after the write edge. The compare made at the write edge itself uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 target low byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| hPos | input | HPOS_W | Horizontal beam position in standard pixels |
| vLine | input | 9 | Current line, 0 at the first visible pixel line |
| frameIrq | input | 1 | Legacy frame interrupt request |
| intOut | output | 1 | Interrupt request level to the processor |

## Verification
The line match and the legacy frame pulse can land in the same clock. The bench provokes this by raising `frameIrq` while the beam sits inside the 256..319 window on the line before the target. It does this once with the frame mask clear and once with it set. In both cases `intOut` must be a plain 1 in the following clock. A frame pulse that arrives outside the window with the mask set must leave `intOut` at 0. The bench also writes a new target while the beam is held on a matching position. It then judges the cycle in which the old target still applies and the cycle in which the new one takes over.

// File: rtl/rli_pkg.sv
package rli_pkg;
  localparam int TGT_W = 9;   // target line width fixed by the register layout
  localparam int REG_W = 8;

  // Bit positions inside the control register
  localparam int CTL_STATUS   = 7;
  localparam int CTL_FRAME_DIS = 2;
  localparam int CTL_LINE_EN  = 1;
  localparam int CTL_TGT_HI   = 0;

  typedef struct packed {
    logic             ldCtrl;  // load control fields
    logic             ldLow;   // load target low byte
    logic [REG_W-1:0] data;    // payload for either load
  } rliStrobe_t;
endpackage

// File: rtl/rli_ctrl.sv
module rli_ctrl
  import rli_pkg::*;
(
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [TGT_W-1:0] curTgt,
  input  logic             curLineEn,
  input  logic             curFrameDis,
  input  logic             curInt,
  output rliStrobe_t       strobe,
  output logic [REG_W-1:0] rdData
);
  always_comb begin
    strobe.ldCtrl = regWrEn && (regAddr == 1'b0);
    strobe.ldLow  = regWrEn && (regAddr == 1'b1);
    strobe.data   = regWrData;
  end

  always_comb begin
    rdData = '0;
    if (regAddr) begin
      rdData = curTgt[REG_W-1:0];
    end else begin
      rdData[CTL_STATUS]    = curInt;
      rdData[CTL_FRAME_DIS] = curFrameDis;
      rdData[CTL_LINE_EN]   = curLineEn;
      rdData[CTL_TGT_HI]    = curTgt[TGT_W-1];
    end
  end
endmodule

// File: rtl/rli_datapath.sv
module rli_datapath
  import rli_pkg::*;
#(
  parameter int LINE_COUNT = 312,
  parameter int HPOS_W     = 10,
  parameter int H_WIN_LO   = 256,
  parameter int H_WIN_HI   = 319
) (
  input  logic              clk,
  input  logic              rstN,
  input  rliStrobe_t        strobe,
  input  logic [HPOS_W-1:0] hPos,
  input  logic [TGT_W-1:0]  vLine,
  input  logic              frameIrq,
  output logic [TGT_W-1:0]  curTgt,
  output logic              curLineEn,
  output logic              curFrameDis,
  output logic              intOut
);
  localparam logic [HPOS_W-1:0] WIN_LO    = HPOS_W'(H_WIN_LO);
  localparam logic [HPOS_W-1:0] WIN_HI    = HPOS_W'(H_WIN_HI);
  localparam logic [TGT_W-1:0]  LAST_LINE = TGT_W'(LINE_COUNT - 1);
  localparam logic [TGT_W:0]    LINE_LIM  = (TGT_W+1)'(LINE_COUNT);

  logic [TGT_W-1:0] prevTgt;
  logic tgtValid, inWindow, lineHit, frameHit;

  // Line whose trailing blank precedes the target, wrapping at frame end
  always_comb begin
    prevTgt  = (curTgt == '0) ? LAST_LINE : curTgt - 1'b1;
    tgtValid = {1'b0, curTgt} < LINE_LIM;
    inWindow = (hPos >= WIN_LO) && (hPos <= WIN_HI);
    lineHit  = curLineEn && tgtValid && (vLine == prevTgt) && inWindow;
    frameHit = frameIrq && !curFrameDis;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTgt      <= '0;
      curLineEn   <= 1'b0;
      curFrameDis <= 1'b0;
      intOut      <= 1'b0;
    end else begin
      if (strobe.ldCtrl) begin
        curTgt[TGT_W-1] <= strobe.data[CTL_TGT_HI];
        curLineEn       <= strobe.data[CTL_LINE_EN];
        curFrameDis     <= strobe.data[CTL_FRAME_DIS];
      end
      if (strobe.ldLow) curTgt[REG_W-1:0] <= strobe.data;
      intOut <= lineHit || frameHit;
    end
  end

  AST_LINE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!curLineEn && !frameIrq) |=> !intOut); // R7
  AST_FRAME_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (frameIrq && !curFrameDis) |=> intOut); // R8
  AST_WRAP_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (curLineEn && curTgt == '0 && vLine == LAST_LINE && inWindow) |=> intOut); // R5
  AST_RANGE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, curTgt} >= LINE_LIM && !frameIrq) |=> !intOut); // R6
endmodule

// File: rtl/raster_line_irq.sv
module raster_line_irq
  import rli_pkg::*;
#(
  parameter int LINE_COUNT = 312,
  parameter int HPOS_W     = 10,
  parameter int H_WIN_LO   = 256,
  parameter int H_WIN_HI   = 319
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [HPOS_W-1:0] hPos,
  input  logic [8:0]        vLine,
  input  logic              frameIrq,
  output logic              intOut
);
  rliStrobe_t       strobe;
  logic [TGT_W-1:0] curTgt;
  logic             curLineEn, curFrameDis;

  rli_ctrl u_ctrl (
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .curTgt      (curTgt),
    .curLineEn   (curLineEn),
    .curFrameDis (curFrameDis),
    .curInt      (intOut),
    .strobe      (strobe),
    .rdData      (regRdData)
  );

  rli_datapath #(
    .LINE_COUNT (LINE_COUNT),
    .HPOS_W     (HPOS_W),
    .H_WIN_LO   (H_WIN_LO),
    .H_WIN_HI   (H_WIN_HI)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hPos        (hPos),
    .vLine       (vLine),
    .frameIrq    (frameIrq),
    .curTgt      (curTgt),
    .curLineEn   (curLineEn),
    .curFrameDis (curFrameDis),
    .intOut      (intOut)
  );

  AST_INT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ($past(frameIrq) ||
               ($past(hPos) >= HPOS_W'(H_WIN_LO) && $past(hPos) <= HPOS_W'(H_WIN_HI)))); // R4
endmodule

// File: tb/raster_line_irq_tb.sv
module raster_line_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 312;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [9:0] hPos = '0;
  logic [8:0] vLine = '0;
  logic       frameIrq = 1'b0;
  logic       intOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_line_irq u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hPos(hPos),
    .vLine(vLine), .frameIrq(frameIrq), .intOut(intOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // Drive beam inputs, let one edge pass, return intOut at the following negedge
  task automatic step(input int h, input int v, input logic f, output logic o);
    @(negedge clk);
    hPos = 10'(h); vLine = 9'(v); frameIrq = f;
    @(negedge clk);
    o = intOut;
  endtask

  task automatic expectAt(input string tag, input int h, input int v, input logic f, input logic exp);
    logic o;
    step(h, v, f, o);
    check(tag, {7'b0, o}, {7'b0, exp});
  endtask

  task automatic setTarget(input int tgt, input logic [2:0] flags);
    writeReg(1'b1, 8'(tgt));
    writeReg(1'b0, {5'b0, flags[2:1], 1'(tgt >> 8)});
  endtask

  task automatic testReset;
    logic [7:0] d;
    readReg(1'b0, d); check("R1 ctrl", d, 8'h00);
    readReg(1'b1, d); check("R1 low", d, 8'h00);
    check("R1 int", {7'b0, intOut}, 8'h00);
  endtask

  task automatic testRegs;
    logic [7:0] d;
    writeReg(1'b0, 8'hFF);
    readReg(1'b0, d); check("R2 ctrl reserved", d, 8'h07);
    writeReg(1'b1, 8'hA5);
    readReg(1'b1, d); check("R2 low", d, 8'hA5);
    writeReg(1'b0, 8'h00);
    readReg(1'b0, d); check("R2 ctrl clear", d, 8'h00);
  endtask

  task automatic testLineMatch;
    logic [7:0] d;
    logic o;
    setTarget(100, 3'b010);
    expectAt("R4 below win", 255, 99, 1'b0, 1'b0);
    expectAt("R3 win lo", 256, 99, 1'b0, 1'b1);
    expectAt("R3 win hi", 319, 99, 1'b0, 1'b1);
    expectAt("R4 above win", 320, 99, 1'b0, 1'b0);
    expectAt("R4 target line", 256, 100, 1'b0, 1'b0);
    expectAt("R4 two before", 256, 98, 1'b0, 1'b0);
    step(300, 99, 1'b0, o);
    readReg(1'b0, d); check("R9 status set", d, 8'h82);
    step(0, 99, 1'b0, o);
    readReg(1'b0, d); check("R9 status clear", d, 8'h02);
  endtask

  task automatic testWrap;
    setTarget(0, 3'b010);
    expectAt("R5 tgt0 last line", 260, LINES-1, 1'b0, 1'b1);
    expectAt("R5 tgt0 line0", 260, 0, 1'b0, 1'b0);
    setTarget(256, 3'b010);
    expectAt("R5 tgt256", 260, 255, 1'b0, 1'b1);
    expectAt("R5 tgt256 low alias", 260, 255 - 256 + LINES, 1'b0, 1'b0);
    setTarget(LINES-1, 3'b010);
    expectAt("R5 tgt last", 260, LINES-2, 1'b0, 1'b1);
  endtask

  task automatic testRange;
    int hits;
    logic o;
    for (int t = 0; t < 2; t++) begin
      setTarget(t == 0 ? 400 : LINES, 3'b010);
      hits = 0;
      for (int v = 0; v < LINES; v++) begin
        step(260, v, 1'b0, o);
        if (o) hits++;
      end
      check("R6 out of range", 8'(hits), 8'h00);
    end
  endtask

  task automatic testDisable;
    setTarget(100, 3'b000);
    expectAt("R7 line disabled", 260, 99, 1'b0, 1'b0);
  endtask

  task automatic testFrame;
    setTarget(100, 3'b000);
    expectAt("R8 frame passes", 0, 0, 1'b1, 1'b1);
    expectAt("R8 frame drops", 0, 0, 1'b0, 1'b0);
    setTarget(100, 3'b100);
    expectAt("R8 frame masked", 0, 0, 1'b1, 1'b0);
  endtask

  task automatic testOverlap;
    setTarget(100, 3'b010);
    expectAt("R10 both", 260, 99, 1'b1, 1'b1);
    setTarget(100, 3'b110);
    expectAt("R10 masked frame keeps line", 260, 99, 1'b1, 1'b1);
    expectAt("R10 masked frame alone", 0, 0, 1'b1, 1'b0);
  endtask

  task automatic testMidFrame;
    setTarget(100, 3'b010);
    expectAt("R11 before change", 260, 99, 1'b0, 1'b1);
    writeReg(1'b1, 8'd101);
    check("R11 old value at write edge", {7'b0, intOut}, 8'h01);
    expectAt("R11 new target no hit", 260, 99, 1'b0, 1'b0);
    expectAt("R11 new target hit", 260, 100, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testRegs();
    testLineMatch();
    testWrap();
    testRange();
    testDisable();
    testFrame();
    testOverlap();
    testMidFrame();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule